// File: doc/BRIEF.md
# Thermal Contrast Heater Controller

This block decides when to switch on the on-die heater of a swept-finger thermal image sensor. Once per frame the sensor reports a 4-bit temperature code. The code is relative: code 8 means no change, and each step near the middle of the scale is 1.4 K. The two end codes, 0 and 15, are saturated and only give a bound on the magnitude. When the host sees a low-contrast image, it raises a request. The block then takes the code of the next frame as its baseline and turns the heater on. It turns the heater off once a later frame reports a code two steps above that baseline, or the top code 15. The controller does not run for a fixed time and does not aim at an absolute temperature.

Heating is slow, at roughly one kelvin per second, so the block counts frames while it heats. If the target code does not arrive within a host-set number of frames, the heater goes off and a sticky timeout flag is raised. The host can drop the enable or pulse abort at any time, and the heater is released at once. Every reported code is also converted into a signed temperature difference in tenths of a kelvin for the host to read.

Top module: `heat_ctrl_top`

## Requirements
- R1: While reset is asserted, and after reset is released, heater_en_o, busy_o and timeout_o are 0 and delta_o is 0.
- R2: One cycle after a clock edge with temp_valid_i high, delta_o holds the signed tenths-of-kelvin value of temp_code_i: code 0 gives -168, code 1 gives -112, code 15 gives +112, and codes 2 to 14 give (code-8)*14. While temp_valid_i is low, delta_o does not change.
- R3: low_contrast_i high in idle with enable_i high sets busy_o on the next cycle. heater_en_o stays 0 until a baseline frame arrives.
- R4: A baseline frame (the first valid frame after the request) with code b < 15 sets heater_en_o on the next cycle, with the target min(b+2, 15). heater_en_o is never 1 while busy_o is 0.
- R5: While heating, a valid frame with a code at or above the target clears heater_en_o and busy_o on the next cycle.
- R6: A baseline frame with code 15 ends the request with no heating: busy_o falls on the next cycle and heater_en_o stays 0.
- R7: While heating, valid frames that miss the target are counted. The frame that brings the count to frame_limit_i (a limit of 0 acts as 1) clears heater_en_o and busy_o and sets timeout_o. timeout_o stays high until the next accepted request clears it, and it is never high while the heater is on.
- R8: abort_i high, or enable_i low, while busy clears heater_en_o and busy_o on the next cycle and does not set timeout_o.
- R9: A request with enable_i low, or a request while busy, is ignored: the baseline and target already held do not change.
- R10: A frame that reaches the target and also exhausts the frame limit ends heating without a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| enable_i | input | 1 | Controller enable |
| abort_i | input | 1 | Forces the heater off at once |
| low_contrast_i | input | 1 | Host request to heat |
| temp_code_i | input | 4 | Temperature code of the current frame |
| temp_valid_i | input | 1 | One-cycle strobe that marks a new frame code |
| frame_limit_i | input | FRAME_CNT_W | Maximum number of heating frames |
| heater_en_o | output | 1 | Heater enable; 1 turns the heater on |
| busy_o | output | 1 | A request is in progress (waiting for a baseline or heating) |
| timeout_o | output | 1 | Sticky flag: the target was not reached in time |
| delta_o | output | DELTA_W (signed) | Temperature difference of the last code, in 0.1 K |

## Verification
The bench builds the block with an 8-bit frame counter instead of the default 16 bits, and uses frame limits of 1, 3 and 10. With these values a timeout, and a target that arrives on the last allowed frame, each take only a few frames to reach. All sixteen codes are swept through the conversion, including both saturated ends. The baseline runs cover a mid-scale code, code 14 (whose target is capped at 15) and the saturated code 15.

// File: rtl/heat_pkg.sv
package heat_pkg;
  localparam int CODE_W   = 4;
  localparam int CODE_MAX = (1 << CODE_W) - 1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_HEAT = 2'd2
  } heat_state_e;
endpackage

// File: rtl/heat_code_lut.sv
module heat_code_lut #(
  parameter int DELTA_W = 9,
  parameter int STEP    = 14
) (
  input  logic [heat_pkg::CODE_W-1:0] code_i,
  output logic signed [DELTA_W-1:0]   delta_o
);
  localparam int MID = 1 << (heat_pkg::CODE_W - 1);

  int d;

  // The middle of the scale is linear; the three end codes are non-uniform.
  always_comb begin
    if (code_i == '0) begin
      d = -12 * STEP;
    end else if (code_i == heat_pkg::CODE_W'(1)) begin
      d = -8 * STEP;
    end else if (code_i == heat_pkg::CODE_W'(heat_pkg::CODE_MAX)) begin
      d = 8 * STEP;
    end else begin
      d = (int'(code_i) - MID) * STEP;
    end
    delta_o = DELTA_W'(d);
  end
endmodule

// File: rtl/heat_frame_timer.sv
module heat_frame_timer #(
  parameter int FRAME_CNT_W = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clear_i,
  input  logic                   tick_i,
  input  logic [FRAME_CNT_W-1:0] limit_i,
  output logic                   expire_o
);
  localparam logic [FRAME_CNT_W-1:0] CNT_MAX = '1;

  logic [FRAME_CNT_W-1:0] cnt_q, cnt_d;
  logic                   cnt_en;
  logic [FRAME_CNT_W:0]   cnt_inc;

  assign cnt_inc  = {1'b0, cnt_q} + 1'b1;
  assign expire_o = tick_i && (cnt_inc >= {1'b0, limit_i});

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (clear_i) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (tick_i && (cnt_q != CNT_MAX)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_inc[FRAME_CNT_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/heat_fsm.sv
module heat_fsm #(
  parameter int RISE_CODES = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        enable_i,
  input  logic                        abort_i,
  input  logic                        req_i,
  input  logic [heat_pkg::CODE_W-1:0] code_i,
  input  logic                        valid_i,
  input  logic                        expire_i,
  output logic                        tmr_clear_o,
  output logic                        tmr_tick_o,
  output logic                        heater_o,
  output logic                        busy_o,
  output logic                        timeout_o
);
  import heat_pkg::*;

  localparam logic [CODE_W-1:0] TOP     = CODE_W'(CODE_MAX);
  localparam logic [CODE_W-1:0] RISE    = CODE_W'(RISE_CODES);
  localparam logic [CODE_W-1:0] CAP_LIM = CODE_W'(CODE_MAX - RISE_CODES);

  heat_state_e       state_q, state_d;
  logic [CODE_W-1:0] target_q, target_d;
  logic              target_en;
  logic              timeout_q, timeout_d;
  logic              stop;

  assign stop = abort_i || !enable_i;

  always_comb begin
    state_d   = state_q;
    target_d  = target_q;
    target_en = 1'b0;
    timeout_d = timeout_q;
    unique case (state_q)
      ST_IDLE: begin
        if (enable_i && req_i && !abort_i) begin
          state_d   = ST_ARM;
          timeout_d = 1'b0;
        end
      end
      ST_ARM: begin
        if (stop) begin
          state_d = ST_IDLE;
        end else if (valid_i) begin
          if (code_i == TOP) begin
            state_d = ST_IDLE;
          end else begin
            state_d   = ST_HEAT;
            target_en = 1'b1;
            target_d  = (code_i >= CAP_LIM) ? TOP : code_i + RISE;
          end
        end
      end
      ST_HEAT: begin
        if (stop) begin
          state_d = ST_IDLE;
        end else if (valid_i) begin
          if (code_i >= target_q) begin
            state_d = ST_IDLE;
          end else if (expire_i) begin
            state_d   = ST_IDLE;
            timeout_d = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      timeout_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      timeout_q <= timeout_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      target_q <= '0;
    end else if (target_en) begin
      target_q <= target_d;
    end
  end

  assign heater_o    = (state_q == ST_HEAT);
  assign busy_o      = (state_q != ST_IDLE);
  assign timeout_o   = timeout_q;
  assign tmr_clear_o = (state_q != ST_HEAT);
  assign tmr_tick_o  = (state_q == ST_HEAT) && valid_i && !stop && (code_i < target_q);

  assert_sat_no_heat_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ARM && valid_i && !stop && code_i == TOP) |=> (!heater_o && !busy_o));

  assert_release_on_target_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (heater_o && valid_i && !stop && code_i >= target_q) |=> (!heater_o && !timeout_o));

  assert_stop_no_timeout_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && stop) |=> (!heater_o && !busy_o && ($past(timeout_o) == timeout_o)));

  assert_timeout_cool_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> !heater_o);
endmodule

// File: rtl/heat_ctrl_top.sv
module heat_ctrl_top #(
  parameter int FRAME_CNT_W = 16,
  parameter int DELTA_W     = 9,
  parameter int RISE_CODES  = 2,
  parameter int STEP_TENTHS = 14
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      enable_i,
  input  logic                      abort_i,
  input  logic                      low_contrast_i,
  input  logic [3:0]                temp_code_i,
  input  logic                      temp_valid_i,
  input  logic [FRAME_CNT_W-1:0]    frame_limit_i,
  output logic                      heater_en_o,
  output logic                      busy_o,
  output logic                      timeout_o,
  output logic signed [DELTA_W-1:0] delta_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  logic signed [DELTA_W-1:0] lut_delta;
  logic signed [DELTA_W-1:0] delta_q;
  logic                      tmr_clear, tmr_tick, tmr_expire;

  heat_code_lut #(
    .DELTA_W (DELTA_W),
    .STEP    (STEP_TENTHS)
  ) u_lut (
    .code_i  (temp_code_i),
    .delta_o (lut_delta)
  );

  always_ff @(posedge clk_i or negedge rst_int_n) begin
    if (!rst_int_n) begin
      delta_q <= '0;
    end else if (temp_valid_i) begin
      delta_q <= lut_delta;
    end
  end
  assign delta_o = delta_q;

  heat_frame_timer #(
    .FRAME_CNT_W (FRAME_CNT_W)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_int_n),
    .clear_i  (tmr_clear),
    .tick_i   (tmr_tick),
    .limit_i  (frame_limit_i),
    .expire_o (tmr_expire)
  );

  heat_fsm #(
    .RISE_CODES (RISE_CODES)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_int_n),
    .enable_i    (enable_i),
    .abort_i     (abort_i),
    .req_i       (low_contrast_i),
    .code_i      (temp_code_i),
    .valid_i     (temp_valid_i),
    .expire_i    (tmr_expire),
    .tmr_clear_o (tmr_clear),
    .tmr_tick_o  (tmr_tick),
    .heater_o    (heater_en_o),
    .busy_o      (busy_o),
    .timeout_o   (timeout_o)
  );

  assert_delta_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    !temp_valid_i |=> $stable(delta_o));

  assert_heat_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    heater_en_o |-> busy_o);

  always_comb begin
    if (!rst_ni) begin
      assert_reset_quiet_R1: assert (!heater_en_o || $isunknown(heater_en_o));
    end
  end
endmodule

// File: tb/heat_ctrl_top_bench.sv
module heat_ctrl_top_bench;
  localparam int FW = 8;
  localparam int EXP_DELTA [16] = '{-168, -112, -84, -70, -56, -42, -28, -14,
                                    0, 14, 28, 42, 56, 70, 84, 112};

  logic          clk = 1'b0;
  logic          rst_n;
  logic          en, abrt, lc, vld;
  logic [3:0]    code;
  logic [FW-1:0] lim;
  logic          heat, busy, tout;
  logic signed [8:0] delta;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  heat_ctrl_top #(.FRAME_CNT_W(FW)) u_heat_ctrl_top (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .abort_i(abrt),
    .low_contrast_i(lc), .temp_code_i(code), .temp_valid_i(vld),
    .frame_limit_i(lim), .heater_en_o(heat), .busy_o(busy),
    .timeout_o(tout), .delta_o(delta));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic frame(input int c);
    @(negedge clk); code = 4'(c); vld = 1'b1;
    @(negedge clk); vld = 1'b0;
  endtask

  task automatic request();
    @(negedge clk); lc = 1'b1;
    @(negedge clk); lc = 1'b0;
  endtask

  task automatic pulse_abort();
    @(negedge clk); abrt = 1'b1;
    @(negedge clk); abrt = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b1; abrt = 1'b0; lc = 1'b0; vld = 1'b0;
    code = 4'd8; lim = 8'd10;
    repeat (2) @(negedge clk);
    chk("R1 heater in reset", int'(heat), 0);
    chk("R1 busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 heater after reset", int'(heat), 0);
    chk("R1 timeout after reset", int'(tout), 0);
    chk("R1 delta after reset", int'(delta), 0);

    // Table walk over all codes (R2).
    for (int i = 0; i < 16; i++) begin
      frame(i);
      chk($sformatf("R2 delta code %0d", i), int'(delta), EXP_DELTA[i]);
    end
    code = 4'd3;
    repeat (3) @(negedge clk);
    chk("R2 delta held without strobe", int'(delta), 112);

    // Normal run: baseline 6, target 8 (R3, R4, R5).
    request();
    chk("R3 busy after request", int'(busy), 1);
    chk("R3 heater waits for baseline", int'(heat), 0);
    frame(6);
    chk("R4 heater on after baseline", int'(heat), 1);
    frame(7);
    chk("R5 heater on below target", int'(heat), 1);
    frame(8);
    chk("R5 heater off at target", int'(heat), 0);
    chk("R5 busy off at target", int'(busy), 0);
    chk("R5 no timeout", int'(tout), 0);

    // Capped target: baseline 14 -> target 15 (R4).
    request();
    frame(14);
    chk("R4 heater on baseline 14", int'(heat), 1);
    frame(14);
    chk("R4 still heating at 14", int'(heat), 1);
    frame(15);
    chk("R4 capped target reached", int'(heat), 0);

    // Saturated baseline (R6).
    request();
    frame(15);
    chk("R6 no heat on saturated baseline", int'(heat), 0);
    chk("R6 busy drops", int'(busy), 0);

    // Timeout after three frames (R7).
    lim = 8'd3;
    request();
    frame(5);
    frame(5);
    frame(6);
    chk("R7 heating before limit", int'(heat), 1);
    frame(6);
    chk("R7 heater off at limit", int'(heat), 0);
    chk("R7 timeout set", int'(tout), 1);
    repeat (5) @(negedge clk);
    chk("R7 timeout sticky", int'(tout), 1);
    request();
    chk("R7 timeout cleared by request", int'(tout), 0);
    pulse_abort();

    // Target on the last allowed frame (R10).
    lim = 8'd1;
    request();
    frame(4);
    frame(6);
    chk("R10 heater off", int'(heat), 0);
    chk("R10 no timeout", int'(tout), 0);

    // Abort and enable drop (R8).
    lim = 8'd10;
    request();
    frame(4);
    pulse_abort();
    chk("R8 abort heater off", int'(heat), 0);
    chk("R8 abort busy off", int'(busy), 0);
    chk("R8 abort no timeout", int'(tout), 0);
    request();
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    chk("R8 enable drop ends wait", int'(busy), 0);

    // Ignored requests (R9).
    request();
    chk("R9 request ignored when disabled", int'(busy), 0);
    en = 1'b1;
    request();
    frame(4);
    request();
    chk("R9 request while heating keeps heater", int'(heat), 1);
    frame(5);
    chk("R9 target unchanged below", int'(heat), 1);
    frame(6);
    chk("R9 target unchanged reached", int'(heat), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule